// File: doc/BRIEF.md
# T1-to-E1 Backplane Frame Mapper

The mapper takes one received T1 frame, an F-bit plus 24 payload octets, and sends it out as a serial 256-bit backplane frame of 32 octets. It sends one bit per cycle of a free-running 2.048 MHz serial clock, so frames repeat 8000 times per second. E1 slot 0 carries the F-bit in its most significant bit. The payload octets fill the other slots in groups of three. After each group comes one filler octet, so the 24 T1 slots end in E1 slot 31.

Payload is written through a parallel write port into the shadow half of a double-buffered frame store. A commit strobe marks the shadow frame as complete. The halves swap only at the next frame start, so the frame on the wire is never torn. A frame sync pulse restarts the frame at bit 0 of slot 0. Without a pulse, the bit counter wraps by itself. The block also reports the current E1 slot number and a strobe on the first bit of each slot.

The sequencer is a four-state machine:
- `S_WAIT` is the state after reset. Nothing is sent until the first sync.
- `S_FBIT` covers slot 0.
- `S_DATA` covers payload slots.
- `S_FILL` covers filler slots.

Its transitions are:
- WAIT→FBIT on the first sync.
- FBIT→DATA at the end of slot 0.
- DATA→DATA between payload slots of one group.
- DATA→FILL before slots 4, 8, …, 28.
- FILL→DATA after a filler slot.
- DATA→FBIT when the counter wraps after slot 31.
- Any running state →FBIT on a sync pulse.

Top module: `t1e1_bp_mapper`

## Requirements
- R1: After reset and until the first sampled `frame_sync`, `ser_out` is 1, `ts_idx` is 0 and `ts_strobe` is 0, even if a frame has been written and committed.
- R2: When `frame_sync` is sampled high on a rising edge, the outputs right after that edge present bit 0 of slot 0. This holds at any point in a frame, so a mid-frame pulse realigns at once.
- R3: Without a sync pulse, bit 0 of slot 0 follows again exactly 256 cycles after the previous one.
- R4: In slot 0, the first bit sent is the F-bit, and the other seven bits are 1. The F-bit is written as `wr_data[0]` at `wr_addr` 24.
- R5: The payload octet written at `wr_addr` n (0..23) is sent in E1 slot n + floor(n/3) + 1, most significant bit first.
- R6: Slots 4, 8, 12, 16, 20, 24 and 28 are sent as all ones.
- R7: `ts_idx` gives the slot of the bit currently on `ser_out`. `ts_strobe` is 1 exactly on bit 0 of each slot while running.
- R8: Writes go to the shadow buffer and never change the frame being sent. After `wr_commit`, the new frame is sent from the next frame start, whether that start comes from a sync or from a wrap. Without a commit, the active frame is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Free-running 2.048 MHz serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High pulse: restart at bit 0 of slot 0 |
| wr_en | input | 1 | Write strobe for the shadow frame store |
| wr_addr | input | 5 | 0..23 payload octet, 24 F-bit |
| wr_data | input | 8 | Write data (F-bit in bit 0) |
| wr_commit | input | 1 | Shadow frame complete; swap at next frame start |
| ser_out | output | 1 | Serial backplane data, changes after the rising edge |
| ts_idx | output | 5 | E1 slot of the current bit |
| ts_strobe | output | 1 | High on bit 0 of each slot |

## Verification
All outputs are decoded from registered state. A sync sampled on one edge therefore shows slot 0 bit 0 right after that edge. Each later bit follows one cycle after the one before. A commit takes effect at the first frame start after it.

The bench drives inputs 1 ns after a rising edge and samples on the falling edge. As soon as the sync edge has passed, the driver queues one expected bit, slot number and strobe per cycle. The monitor pops one item on each falling edge, so the n-th item is compared against the n-th bit of the frame. On a mid-frame sync, the queue is flushed and refilled right after the sync edge.

// File: rtl/t1e1_map_pkg.sv
package t1e1_map_pkg;

    typedef enum logic [1:0] {
        S_WAIT = 2'd0,
        S_FBIT = 2'd1,
        S_DATA = 2'd2,
        S_FILL = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        K_FBIT = 2'd0,
        K_DATA = 2'd1,
        K_FILL = 2'd2
    } slot_kind_t;

    // Slot 0 holds the F-bit; every span-th slot after it is filler.
    function automatic slot_kind_t slot_kind(input int unsigned slot, input int unsigned span);
        if (slot == 0)
            return K_FBIT;
        else if ((slot % span) == 0)
            return K_FILL;
        else
            return K_DATA;
    endfunction

    function automatic seq_state_t state_for(input slot_kind_t k);
        unique case (k)
            K_FBIT:  return S_FBIT;
            K_FILL:  return S_FILL;
            default: return S_DATA;
        endcase
    endfunction

endpackage

// File: rtl/t1e1_slot_map.sv
module t1e1_slot_map #(
    parameter int GROUP = 3,
    parameter int SW    = 5,
    parameter int TW    = 5
) (
    input  logic [SW-1:0] slot,
    output logic [TW-1:0] t1_idx
);
    localparam int SPAN = GROUP + 1;

    int s_i;
    int idx_i;

    // Inverse of e1 = n + n/GROUP + 1 for payload slots.
    always_comb begin
        s_i = 32'(slot);
        if (s_i == 0 || (s_i % SPAN) == 0)
            idx_i = 0;
        else
            idx_i = s_i - (s_i / SPAN) - 1;
        t1_idx = TW'(idx_i);
    end
endmodule

// File: rtl/t1e1_frame_store.sv
module t1e1_frame_store #(
    parameter int T1_SLOTS = 24,
    parameter int OCT_W    = 8,
    parameter int AW       = 5,
    parameter int TW       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [OCT_W-1:0] wr_data,
    input  logic             wr_commit,
    input  logic             frame_start,
    input  logic [TW-1:0]    rd_idx,
    output logic [OCT_W-1:0] rd_octet,
    output logic             rd_fbit,
    output logic             bank_sel
);
    localparam int NBANK = 2;
    localparam logic [AW-1:0] F_ADDR = AW'(T1_SLOTS);

    logic [OCT_W-1:0] mem  [NBANK][T1_SLOTS];
    logic             fbit [NBANK];
    logic             pending;

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < T1_SLOTS; i++) mem[g][i] <= '0;
                    fbit[g] <= 1'b0;
                end else if (wr_en && (bank_sel != 1'(g))) begin
                    if (wr_addr == F_ADDR)
                        fbit[g] <= wr_data[0];
                    else if (32'(wr_addr) < T1_SLOTS)
                        mem[g][wr_addr] <= wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel <= 1'b0;
            pending  <= 1'b0;
        end else begin
            if (frame_start && pending)
                bank_sel <= ~bank_sel;
            pending <= wr_commit | (pending & ~frame_start);
        end
    end

    always_comb begin
        rd_octet = (32'(rd_idx) < T1_SLOTS) ? mem[bank_sel][rd_idx] : '1;
        rd_fbit  = fbit[bank_sel];
    end
endmodule

// File: rtl/t1e1_bit_seq.sv
module t1e1_bit_seq
    import t1e1_map_pkg::*;
#(
    parameter int E1_SLOTS = 32,
    parameter int OCT_W    = 8,
    parameter int GROUP    = 3,
    parameter int CW       = $clog2(E1_SLOTS * OCT_W),
    parameter int BW       = $clog2(OCT_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync,
    output seq_state_t    state,
    output logic [CW-1:0] bit_cnt,
    output logic          frame_start
);
    localparam int SPAN = GROUP + 1;
    localparam int SW   = CW - BW;
    localparam logic [CW-1:0] LAST = CW'(E1_SLOTS * OCT_W - 1);

    seq_state_t    st_nxt;
    logic [CW-1:0] cnt_nxt;
    logic [SW-1:0] nslot;

    // Next-count and next-state logic.
    always_comb begin
        cnt_nxt = bit_cnt;
        if (sync)
            cnt_nxt = '0;
        else if (state != S_WAIT)
            cnt_nxt = (bit_cnt == LAST) ? '0 : CW'(bit_cnt + 1'b1);
        nslot = cnt_nxt[CW-1:BW];

        st_nxt = state;
        unique case (state)
            S_WAIT: st_nxt = sync ? S_FBIT : S_WAIT;
            S_FBIT, S_DATA, S_FILL:
                st_nxt = state_for(slot_kind(32'(nslot), SPAN));
            default: st_nxt = S_WAIT;
        endcase

        frame_start = sync | ((state != S_WAIT) && (bit_cnt == LAST));
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_WAIT;
            bit_cnt <= '0;
        end else begin
            state   <= st_nxt;
            bit_cnt <= cnt_nxt;
        end
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (bit_cnt == '0 && state == S_FBIT)); // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_WAIT && bit_cnt == LAST && !sync) |=> (bit_cnt == '0 && state == S_FBIT)); // R3
endmodule

// File: rtl/t1e1_bp_mapper.sv
module t1e1_bp_mapper
    import t1e1_map_pkg::*;
#(
    parameter int E1_SLOTS = 32,
    parameter int T1_SLOTS = 24,
    parameter int OCT_W    = 8,
    parameter int GROUP    = 3,
    parameter int AW       = $clog2(T1_SLOTS + 1),
    parameter int SW       = $clog2(E1_SLOTS)
) (
    input  logic             clk_ser,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [OCT_W-1:0] wr_data,
    input  logic             wr_commit,
    output logic             ser_out,
    output logic [SW-1:0]    ts_idx,
    output logic             ts_strobe
);
    localparam int BW = $clog2(OCT_W);
    localparam int CW = SW + BW;
    localparam int TW = $clog2(T1_SLOTS);

    seq_state_t       state;
    logic [CW-1:0]    bit_cnt;
    logic             frame_start;
    logic [TW-1:0]    t1_idx;
    logic [OCT_W-1:0] octet;
    logic             fbit;
    logic             bank_sel;
    logic [BW-1:0]    bit_pos;
    logic [SW-1:0]    slot;

    assign bit_pos = bit_cnt[BW-1:0];
    assign slot    = bit_cnt[CW-1:BW];

    t1e1_bit_seq #(
        .E1_SLOTS(E1_SLOTS), .OCT_W(OCT_W), .GROUP(GROUP), .CW(CW), .BW(BW)
    ) u_seq (
        .clk(clk_ser), .rst_n(rst_n), .sync(frame_sync),
        .state(state), .bit_cnt(bit_cnt), .frame_start(frame_start)
    );

    t1e1_slot_map #(.GROUP(GROUP), .SW(SW), .TW(TW)) u_map (
        .slot(slot), .t1_idx(t1_idx)
    );

    t1e1_frame_store #(
        .T1_SLOTS(T1_SLOTS), .OCT_W(OCT_W), .AW(AW), .TW(TW)
    ) u_store (
        .clk(clk_ser), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit), .frame_start(frame_start),
        .rd_idx(t1_idx), .rd_octet(octet), .rd_fbit(fbit), .bank_sel(bank_sel)
    );

    // Output process: decode registered state into the serial stream.
    always_comb begin
        ser_out   = 1'b1;
        ts_idx    = '0;
        ts_strobe = 1'b0;
        unique case (state)
            S_WAIT: begin
                ser_out = 1'b1;
            end
            S_FBIT: begin
                ser_out   = (bit_pos == '0) ? fbit : 1'b1;
                ts_idx    = slot;
                ts_strobe = (bit_pos == '0);
            end
            S_DATA: begin
                ser_out   = octet[BW'(OCT_W - 1) - bit_pos];
                ts_idx    = slot;
                ts_strobe = (bit_pos == '0);
            end
            S_FILL: begin
                ser_out   = 1'b1;
                ts_idx    = slot;
                ts_strobe = (bit_pos == '0);
            end
            default: ser_out = 1'b1;
        endcase
    end

    AST_STROBE_SPACING: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (ts_strobe && !frame_sync) |=> !ts_strobe); // R7

    AST_SWAP_AT_FRAME_START: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (bank_sel != $past(bank_sel)) |-> (ts_idx == '0 && ts_strobe)); // R8
endmodule

// File: tb/t1e1_bp_mapper_test.sv
`timescale 1ns/1ps
module t1e1_bp_mapper_test;

    typedef struct {
        logic       s;
        logic [4:0] idx;
        logic       stb;
        int         ctx;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_commit = 1'b0;
    logic       ser_out;
    logic [4:0] ts_idx;
    logic       ts_strobe;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    logic [7:0] pay [3][24];
    logic       fbv [3];

    always #2.5 clk = ~clk;

    t1e1_bp_mapper uut (
        .clk_ser(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
        .ser_out(ser_out), .ts_idx(ts_idx), .ts_strobe(ts_strobe)
    );

    // Expected bit c of frame f, from R4, R5 and R6.
    function automatic exp_t expect_bit(int f, int c, int ctx);
        exp_t e;
        int slot = c / 8;
        int b = c % 8;
        e.idx = 5'(slot);
        e.stb = (b == 0);
        e.ctx = ctx;
        if (slot == 0)
            e.s = (b == 0) ? fbv[f] : 1'b1;
        else if (slot % 4 == 0)
            e.s = 1'b1;
        else
            e.s = pay[f][slot - slot / 4 - 1][7 - b];
        return e;
    endfunction

    task automatic push_frame(int f, int ctx);
        for (int c = 0; c < 256; c++) q.push_back(expect_bit(f, c, ctx));
    endtask

    task automatic load_frame(int f);
        for (int n = 0; n < 25; n++) begin
            wr_en   = 1'b1;
            wr_addr = 5'(n);
            wr_data = (n == 24) ? {7'd0, fbv[f]} : pay[f][n];
            @(posedge clk); #1;
        end
        wr_en = 1'b0;
        wr_commit = 1'b1;
        @(posedge clk); #1;
        wr_commit = 1'b0;
    endtask

    task automatic pulse_sync();
        frame_sync = 1'b1;
        @(posedge clk); #1;
        frame_sync = 1'b0;
    endtask

    task automatic check_idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            checks++;
            if (ser_out !== 1'b1 || ts_idx !== 5'd0 || ts_strobe !== 1'b0) begin
                errors++;
                $display("FAIL R1 idle: ser=%b idx=%0d stb=%b expected ser=1 idx=0 stb=0",
                         ser_out, ts_idx, ts_strobe);
            end
        end
        @(posedge clk); #1;
    endtask

    // Monitor: one expected item per falling edge.
    always @(negedge clk) begin
        if (q.size() > 0 && !done) begin
            exp_t e;
            int r;
            e = q.pop_front();
            checks++;
            if (ser_out !== e.s) begin
                r = (e.idx == 0) ? 4 : ((e.idx % 4 == 0) ? 6 : 5); // R4 / R6 / R5
                errors++;
                $display("FAIL R%0d [case R%0d] slot %0d: ser=%b expected %b",
                         r, e.ctx, e.idx, ser_out, e.s);
            end
            if (ts_idx !== e.idx || ts_strobe !== e.stb) begin
                errors++;
                $display("FAIL R7 [case R%0d]: idx=%0d stb=%b expected idx=%0d stb=%b",
                         e.ctx, ts_idx, ts_strobe, e.idx, e.stb);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 3; f++)
            for (int n = 0; n < 24; n++)
                pay[f][n] = 8'(n * 29 + f * 71 + 3);
        pay[1][5] = 8'hFF;
        pay[2][7] = 8'h00;
        fbv[0] = 1'b1;
        fbv[1] = 1'b0;
        fbv[2] = 1'b1;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: quiet before first sync, also with a committed frame.
        check_idle(4);
        load_frame(0);
        check_idle(3);

        // R2: sync starts frame A; R8: B committed during A arrives at wrap;
        // R3: wrap with no sync; R8: B repeats without a new commit.
        pulse_sync();
        push_frame(0, 2);
        push_frame(1, 8);
        push_frame(1, 3);
        load_frame(1);

        // Write C into the shadow buffer during the repeated B frame (R8),
        // then realign mid-frame with a sync (R2).
        while (q.size() > 160) begin @(posedge clk); #1; end
        load_frame(2);
        frame_sync = 1'b1;
        @(posedge clk); #1;
        frame_sync = 1'b0;
        q.delete();
        push_frame(2, 2);
        push_frame(2, 3);

        while (q.size() > 0) begin @(posedge clk); #1; end
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule